// File: doc/BRIEF.md
# Isochronous Cycle Start Generator

This block keeps the isochronous cycle timing of one node on a serial bus. On the node acting as cycle master (root), a free-running period timer raises a transmit request for a cycle-start packet once every nominal 125 µs. The period is given as a count of local clocks, for example 3072 clocks at 24.576 MHz. If the bus is busy when the period runs out, the request is held until the bus goes idle. The timer keeps counting from the nominal expiry, so late sends do not push later cycles back.

On every node, root or not, the cycle-start event that the physical layer reports is turned into a one-clock cycle-sync pulse for the application. A cycle counter steps on each such event and wraps after 8000 cycles, which is one second of cycles. A single cycle start aligns all isochronous channels, so one pulse serves all of them. The application's timing always follows the detected event, never the local timer.

Top module: `iso_cycle_gen`

## Requirements
- R1: After synchronous reset, `tx_req` and `cyc_sync` are 0 and `cyc_count` is 0.
- R2: With `root_en` high, the period timer starts at zero. `tx_req` rises after the PERIOD_CLKS-th clock edge at which `root_en` is sampled high, and again every PERIOD_CLKS edges after that.
- R3: Once raised, `tx_req` stays high while `bus_busy` is sampled high. It drops on the edge after a clock in which it is high and `bus_busy` is low, unless a new period expires on that same edge.
- R4: The time a request is held for a busy bus does not move the next expiry. The next rise of `tx_req` still comes exactly PERIOD_CLKS edges after the previous expiry.
- R5: On any edge where `root_en` is sampled low, `tx_req` goes to 0, even while a request is pending, and the period timer returns to zero. While `root_en` stays low, `tx_req` never rises.
- R6: `cyc_sync` is high for exactly one clock. It is high after the first edge at which `cs_detect` is sampled high following a low sample, however long `cs_detect` then stays high.
- R7: `cyc_count` advances by one on the same edge that raises `cyc_sync`. It holds its value at every other edge.
- R8: `cyc_count` goes from CYCLES_PER_SEC-1 (7999 by default) back to 0.
- R9: `cyc_sync` and `cyc_count` respond to `cs_detect` in the same way whether `root_en` is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Node clock |
| rst | input | 1 | Synchronous active-high reset |
| root_en | input | 1 | Node is root; enables the period timer |
| cs_detect | input | 1 | Cycle start detected by the physical layer (level or strobe) |
| bus_busy | input | 1 | Bus occupied; defers the pending transmit request |
| tx_req | output | 1 | Request to send a cycle-start packet |
| cyc_sync | output | 1 | One-clock cycle synchronisation pulse to the application |
| cyc_count | output | $clog2(CYCLES_PER_SEC) | Cycle number within the current second |

## Verification
A wrong period-timer count shows up as a `tx_req` rise one or more edges early or late. This is visible within one period of enabling the root, and the error grows each period if busy time is wrongly added to the timer. A stuck edge-detect register shows as a second `cyc_sync` pulse, or a missing one, on the clock after `cs_detect` is held high. That error reaches `cyc_count` on the same edge. A wrong wrap constant is visible only at the 8000th event, so the wrap is driven all the way to its end.

// File: rtl/iso_cyc_pkg.sv
package iso_cyc_pkg;
  localparam int DEF_PERIOD_CLKS    = 3072;
  localparam int DEF_CYCLES_PER_SEC = 8000;
endpackage

// File: rtl/iso_period_timer.sv
module iso_period_timer #(
  parameter int PERIOD_CLKS = 3072
) (
  input  logic clk,
  input  logic rst,
  input  logic root_en,
  input  logic bus_busy,
  output logic tx_req
);
  localparam int CW = (PERIOD_CLKS > 2) ? $clog2(PERIOD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

  logic [CW-1:0] tmr;
  logic          expire;

  assign expire = root_en && (tmr == LAST);

  // The timer wraps on its own schedule; the request state never feeds back
  always_ff @(posedge clk) begin
    if (rst || !root_en) begin
      tmr <= '0;
    end else if (tmr == LAST) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !root_en) begin
      tx_req <= 1'b0;
    end else if (expire) begin
      tx_req <= 1'b1;
    end else if (tx_req && !bus_busy) begin
      tx_req <= 1'b0;
    end
  end

  // R5
  root_off_chk: assert property (@(posedge clk) disable iff (rst)
    !root_en |=> !tx_req);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (root_en && tx_req && bus_busy) |=> tx_req);

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !bus_busy && !expire) |=> !tx_req);
endmodule

// File: rtl/iso_sync_pulse.sv
module iso_sync_pulse (
  input  logic clk,
  input  logic rst,
  input  logic cs_detect,
  output logic cyc_sync,
  output logic start_seen
);
  logic det_q;

  assign start_seen = cs_detect && !det_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q    <= 1'b0;
      cyc_sync <= 1'b0;
    end else begin
      det_q    <= cs_detect;
      cyc_sync <= start_seen;
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_sync |=> !cyc_sync);
endmodule

// File: rtl/iso_cycle_counter.sv
module iso_cycle_counter #(
  parameter int WRAP = 8000,
  localparam int W = $clog2(WRAP)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = W'(WRAP - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (advance) begin
      count <= (count == TOP) ? '0 : count + 1'b1;
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(count));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= TOP);
endmodule

// File: rtl/iso_cycle_gen.sv
module iso_cycle_gen
  import iso_cyc_pkg::*;
#(
  parameter int PERIOD_CLKS    = DEF_PERIOD_CLKS,
  parameter int CYCLES_PER_SEC = DEF_CYCLES_PER_SEC,
  localparam int CNT_W = $clog2(CYCLES_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             root_en,
  input  logic             cs_detect,
  input  logic             bus_busy,
  output logic             tx_req,
  output logic             cyc_sync,
  output logic [CNT_W-1:0] cyc_count
);
  logic start_seen;

  iso_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .root_en  (root_en),
    .bus_busy (bus_busy),
    .tx_req   (tx_req)
  );

  iso_sync_pulse u_sync (
    .clk        (clk),
    .rst        (rst),
    .cs_detect  (cs_detect),
    .cyc_sync   (cyc_sync),
    .start_seen (start_seen)
  );

  iso_cycle_counter #(.WRAP(CYCLES_PER_SEC)) u_count (
    .clk     (clk),
    .rst     (rst),
    .advance (start_seen),
    .count   (cyc_count)
  );

  // R7
  sync_count_align_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_sync |-> (cyc_count != $past(cyc_count)));
endmodule

// File: tb/tb_iso_cycle_gen.sv
module tb_iso_cycle_gen;
  localparam int P = 20;
  localparam int CPS = 8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic root_en = 1'b0;
  logic cs_detect = 1'b0;
  logic bus_busy = 1'b0;
  logic tx_req, cyc_sync;
  logic [12:0] cyc_count;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  iso_cycle_gen #(.PERIOD_CLKS(P), .CYCLES_PER_SEC(CPS)) dut (
    .clk(clk), .rst(rst), .root_en(root_en), .cs_detect(cs_detect),
    .bus_busy(bus_busy), .tx_req(tx_req), .cyc_sync(cyc_sync),
    .cyc_count(cyc_count)
  );

  // {cs_detect, expected cyc_sync, expected cyc_count}, root_en low throughout
  localparam logic [14:0] VEC [12] = '{
    {1'b1, 1'b1, 13'd1}, {1'b1, 1'b0, 13'd1}, {1'b1, 1'b0, 13'd1},
    {1'b0, 1'b0, 13'd1}, {1'b1, 1'b1, 13'd2}, {1'b0, 1'b0, 13'd2},
    {1'b1, 1'b1, 13'd3}, {1'b1, 1'b0, 13'd3}, {1'b0, 1'b0, 13'd3},
    {1'b0, 1'b0, 13'd3}, {1'b1, 1'b1, 13'd4}, {1'b0, 1'b0, 13'd4}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse();
    cs_detect = 1'b1;
    tick();
    cs_detect = 1'b0;
    tick();
  endtask

  initial begin
    #(20 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seen_tx;
    repeat (3) tick();
    rst = 1'b0;
    // R1
    check("R1 tx_req", tx_req, 0);
    check("R1 cyc_sync", cyc_sync, 0);
    check("R1 cyc_count", cyc_count, 0);

    // R6 R7 R9 R5: table walk with root disabled
    for (int i = 0; i < 12; i++) begin
      cs_detect = VEC[i][14];
      tick();
      check("R6 cyc_sync", cyc_sync, int'(VEC[i][13]));
      check("R7 cyc_count", cyc_count, int'(VEC[i][12:0]));
      check("R5 tx_req off", tx_req, 0);
    end
    cs_detect = 1'b0;

    // R2: first expiry after P edges
    root_en = 1'b1;
    repeat (P - 1) tick();
    check("R2 before expiry", tx_req, 0);
    tick();
    check("R2 expiry", tx_req, 1);
    tick();
    check("R3 release idle", tx_req, 0);

    // R3 R4: busy hold, then on-schedule next expiry
    bus_busy = 1'b1;
    repeat (P - 2) tick();
    check("R2 before 2nd expiry", tx_req, 0);
    tick();
    check("R2 2nd expiry", tx_req, 1);
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R3 held busy", tx_req, 1);
    end
    bus_busy = 1'b0;
    tick();
    check("R3 release after busy", tx_req, 0);
    repeat (P - 7) tick();
    check("R4 before 3rd expiry", tx_req, 0);
    tick();
    check("R4 3rd expiry no drift", tx_req, 1);
    tick();

    // R9: sync path unchanged on root
    cs_detect = 1'b1;
    tick();
    check("R9 sync on root", cyc_sync, 1);
    check("R9 count on root", cyc_count, 5);
    cs_detect = 1'b0;
    tick();

    // R5: disable, stay silent, restart from zero
    root_en = 1'b0;
    tick();
    check("R5 off", tx_req, 0);
    seen_tx = 0;
    for (int k = 0; k < 3 * P; k++) begin
      tick();
      if (tx_req) seen_tx = 1;
    end
    check("R5 silent while off", seen_tx, 0);
    root_en = 1'b1;
    repeat (P - 1) tick();
    check("R5 restart before", tx_req, 0);
    tick();
    check("R5 restart expiry", tx_req, 1);
    bus_busy = 1'b1;
    root_en = 1'b0;
    tick();
    check("R5 drop pending", tx_req, 0);
    bus_busy = 1'b0;

    // R8: wrap
    for (int k = 0; k < CPS - 6; k++) pulse();
    check("R8 top", cyc_count, CPS - 1);
    cs_detect = 1'b1;
    tick();
    check("R8 wrap sync", cyc_sync, 1);
    check("R8 wrap", cyc_count, 0);
    cs_detect = 1'b0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule